// File: doc/BRIEF.md
# Result-Triggered Serial Transmitter

This block sends a 16-bit computation result out on a single asynchronous serial line as soon as the result is offered. A one-cycle result-valid strobe, sampled while the block is idle, captures the result. The block then sends it as two 8N1 characters: the upper byte first, then the lower byte. A busy flag stays high from the cycle after the strobe is taken until the line has returned to idle. Strobes that arrive during that window are discarded.

The upstream logic raises the strobe whenever it has a new result. It may watch `busy` to learn when a strobe will be taken. A serial adapter on `tx` receives the characters at the configured line rate. The default line rate is 9600 baud from a 12 MHz clock.

Top module: `result_uart_tx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: from the next cycle `tx` is 1 and `busy` is 0, even if a character was half sent.
- R2: Every bit on `tx` lasts exactly DIV = CLK_HZ/BAUD clock cycles (1250 at the 12 MHz / 9600 default). The bit timer restarts at the start bit of every character.
- R3: Each character is a 0 start bit, then eight data bits least significant first, then a single 1 stop bit, with no parity bit.
- R4: The first character carries `res_data[15:8]` and the second carries `res_data[7:0]`. The second start bit begins exactly one clock cycle after the first stop bit ends.
- R5: When `res_valid` is 1 at a rising edge while `busy` is 0, `busy` reads 1 in the next cycle. The start bit appears on `tx` one cycle after that.
- R6: `busy` stays 1 until one cycle after the second stop bit ends, then reads 0. A strobe in the first cycle that `busy` reads 0 is accepted.
- R7: A strobe that arrives while `busy` is 1, including its last cycle, is ignored. The data sent is the value captured at acceptance, and no extra character follows.
- R8: Whenever `busy` is 0, `tx` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | One-cycle strobe: a new result is present |
| res_data | input | 16 | Result to transmit (2*DATA_W bits) |
| tx | output | 1 | Serial data line, idle high |
| busy | output | 1 | 1 while a result transmission is in progress |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before the first strobe. They also assume that `res_valid` and `res_data` are stable around the rising edge, and make no assumption about how often strobes come. The stimulus changes every input only on falling edges. It leaves at least one low-reset edge at start-up. It also deliberately places extra strobes inside the busy window, including its final cycle, so that dropping them is exercised and not merely assumed.

// File: rtl/res_tx_pkg.sv
package res_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD_HI = 3'd1,
    ST_SEND_HI = 3'd2,
    ST_LOAD_LO = 3'd3,
    ST_SEND_LO = 3'd4,
    ST_DONE    = 3'd5
  } ctl_state_t;
endpackage

// File: rtl/res_tx_divider.sv
module res_tx_divider #(
  parameter int DIV = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R2
  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));  // R2
endmodule

// File: rtl/res_tx_shifter.sv
module res_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              tx_o,
  output logic              active_o,
  output logic              done_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               tx_q;
  logic               active_q;

  assign tx_o     = tx_q;
  assign active_o = active_q;
  assign done_o   = active_q && tick_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= '1;
      idx_q    <= '0;
      tx_q     <= 1'b1;
      active_q <= 1'b0;
    end else if (load_i) begin
      frame_q  <= {1'b1, data_i, 1'b0};
      idx_q    <= '0;
      tx_q     <= 1'b0;
      active_q <= 1'b1;
    end else if (active_q && tick_i) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        tx_q     <= 1'b1;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        tx_q    <= frame_q[1];
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_q);  // R4
  AST_STOP_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> tx_q);  // R3
  AST_START_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !tx_q);  // R3
endmodule

// File: rtl/res_tx_ctrl.sv
module res_tx_ctrl
  import res_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [2*DATA_W-1:0] result_i,
  input  logic                done_i,
  output logic                load_o,
  output logic [DATA_W-1:0]   byte_o,
  output logic                busy_o
);
  localparam int RES_W = 2 * DATA_W;

  ctl_state_t       state_q, state_d;
  logic [RES_W-1:0] res_q;
  logic             busy_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (valid_i) state_d = ST_LOAD_HI;
      ST_LOAD_HI: state_d = ST_SEND_HI;
      ST_SEND_HI: if (done_i) state_d = ST_LOAD_LO;
      ST_LOAD_LO: state_d = ST_SEND_LO;
      ST_SEND_LO: if (done_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
      if (state_q == ST_IDLE && valid_i) res_q <= result_i;
    end
  end

  assign load_o = (state_q == ST_LOAD_HI) || (state_q == ST_LOAD_LO);
  assign byte_o = (state_q == ST_LOAD_HI) ? res_q[RES_W-1:DATA_W] : res_q[DATA_W-1:0];
  assign busy_o = busy_q;

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && valid_i) |=> busy_o);  // R5
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(res_q));  // R7
  AST_BUSY_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (state_q != ST_IDLE));  // R6
endmodule

// File: rtl/result_uart_tx.sv
module result_uart_tx #(
  parameter int CLK_HZ = 12_000_000,
  parameter int BAUD   = 9600,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                res_valid,
  input  logic [2*DATA_W-1:0] res_data,
  output logic                tx,
  output logic                busy
);
  localparam int DIV = CLK_HZ / BAUD;

  logic              load;
  logic [DATA_W-1:0] byte_sel;
  logic              tick;
  logic              active;
  logic              frame_done;

  res_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (res_valid),
    .result_i (res_data),
    .done_i   (frame_done),
    .load_o   (load),
    .byte_o   (byte_sel),
    .busy_o   (busy)
  );

  res_tx_divider #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .run_i   (active),
    .tick_o  (tick)
  );

  res_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .data_i   (byte_sel),
    .tick_i   (tick),
    .tx_o     (tx),
    .active_o (active),
    .done_o   (frame_done)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);  // R8
  AST_NO_FRAME_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !active);  // R7
endmodule

// File: tb/result_uart_tx_test.sv
module result_uart_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 50;
  localparam int BAUD       = 10;
  localparam int D          = CLK_HZ / BAUD;
  localparam int W          = 8;
  localparam int LAST_OFF   = 20 * D + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           res_valid = 1'b0;
  logic [2*W-1:0] res_data = '0;
  logic           tx;
  logic           busy;

  int vecs = 0;
  int errs = 0;

  result_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .tx        (tx),
    .busy      (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp, input int off);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s at offset %0d: actual %b expected %b", req, what, off, act, exp);
    end
  endtask

  // expected line level for one character at bit-time offset o (0 = start)
  function automatic logic frame_bit(input logic [W-1:0] b, input int o);
    int k = o / D;
    if (k == 0) return 1'b0;
    if (k <= W) return b[k-1];
    return 1'b1;
  endfunction

  function automatic logic exp_tx(input logic [W-1:0] hi, input logic [W-1:0] lo, input int off);
    if (off < 0) return 1'b1;
    if (off < 10 * D) return frame_bit(hi, off);
    if (off == 10 * D) return 1'b1;
    if (off <= 20 * D) return frame_bit(lo, off - 10 * D - 1);
    return 1'b1;
  endfunction

  function automatic string tx_tag(input int off);
    if (off <= 0) return "R5";
    if (off < 10 * D) return "R2,R3";
    if (off <= 20 * D) return "R4";
    return "R8";
  endfunction

  task automatic run_event(input logic [W-1:0] hi, input logic [W-1:0] lo,
                           input bit drop_mid, input bit drop_last);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = {hi, lo};
    for (int off = -1; off <= LAST_OFF; off++) begin
      @(negedge clk);
      res_valid = 1'b0;
      res_data  = '0;
      chk(tx_tag(off), "tx", tx, exp_tx(hi, lo, off), off);
      chk("R6", "busy", busy, (off <= 20 * D + 1), off);
      if (drop_mid && off == 4) begin
        res_valid = 1'b1;
        res_data  = ~{hi, lo};
      end
      if (drop_last && off == 20 * D + 1) begin
        res_valid = 1'b1;
        res_data  = {lo, hi};
      end
    end
  endtask

  task automatic idle_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "idle tx", tx, 1'b1, i);
      chk(req, "idle busy", busy, 1'b0, i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset tx", tx, 1'b1, 0);
    chk("R1", "reset busy", busy, 1'b0, 0);
    rst_n = 1'b1;
    idle_check(2, "R8");

    // sweep every upper-byte value, back to back, with dropped strobes
    for (int v = 0; v < 256; v++) begin
      run_event(8'(v), 8'(v) ^ 8'hA5, (v % 3) == 0, (v % 2) == 1);
    end
    // no extra character from any dropped strobe
    idle_check(3 * D, "R7");

    // walking ones in the lower byte, with gaps between events
    for (int b = 0; b < W; b++) begin
      run_event(8'h00, 8'(1 << b), 1'b1, 1'b1);
      idle_check(2, "R7");
    end

    // reset in the middle of a character
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = 16'h00FF;
    @(negedge clk);
    res_valid = 1'b0;
    repeat (D + 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid reset tx", tx, 1'b1, 0);
    chk("R1", "mid reset busy", busy, 1'b0, 0);
    rst_n = 1'b1;
    idle_check(2 * D, "R1");
    run_event(8'h3C, 8'hC3, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule